// File: doc/BRIEF.md
# One-Time-Programmable Protection Register Controller

This block decodes bus-write commands for a 128-bit security register inside a flash-style device and holds its contents. The register has two 64-bit halves. The factory half carries a fixed identification value that no command can change. The user half powers up blank (all ones), can be programmed, and can then be sealed for good through a separate lock word. A host writes command words to enter identifier-read mode, where the register appears at fixed addresses, and to return to normal array reads. Programming takes two writes: a setup command, then a write whose address and data say what to program.

Programming is one-way. Bits can only go from 1 to 0, so each program stores the old value ANDed with the new data. The bus is 16 bits wide in word mode. In byte mode only the low 8 bits of the bus are used, so a program touches 8 bits at a time. After a program that is accepted, a busy flag stays high for a fixed number of cycles. A program that is refused sets an error bit in the status output.

Top module: `otp_prot_ctrl`

## Requirements
- R1: After reset the block is in array-read mode, not busy, and has no program error. The user half reads all ones and is unlocked, so `status` = 0x80.
- R2: A write of 0x0090 selects identifier-read mode and a write of 0x00FF selects array-read mode. In array-read mode every read returns 0xFFFF, or 0x00FF in byte mode. In identifier-read mode a read at an unmapped address returns 0.
- R3: In identifier-read mode with word addressing, the lock word sits at BASE (0x80). Factory words sit at BASE+1..BASE+4 and user words at BASE+5..BASE+8, with the least significant word first.
- R4: In byte mode the byte address is twice the word address, plus 1 for the high byte. The byte is returned in `rdata[7:0]` with the upper bits zero. Commands compare only `wdata[7:0]`.
- R5: A write of 0x00C0 arms a program, and the next accepted write programs the location at its address. The stored value becomes old AND data: 16 bits in word mode, or one byte lane in byte mode.
- R6: The factory half never changes. A program aimed at it, or at an address outside the lock word and the user half, is refused and sets `status[4]`. A program that is accepted clears `status[4]`.
- R7: The lock word resets to 0xFFFE. Clearing its bit 1 locks the user half permanently, and `status[1]` is then 1. After that, programs to the user half are refused.
- R8: After a program is accepted, `busy` is high for exactly PROG_CYCLES cycles and `status[7]` reads 0. Writes that arrive while `busy` is high are ignored.
- R9: A program sequence leaves the read mode unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe, one write per cycle |
| addr | input | ADDR_W | Word address, or byte address in byte mode |
| wdata | input | 16 | Command or program data |
| byte_mode | input | 1 | 1 selects byte-wide addressing and data |
| rdata | output | 16 | Read data for `addr`, combinational |
| busy | output | 1 | Program in progress |
| status | output | 8 | Bit 7 ready, bit 4 program error, bit 1 user half locked |

## Verification
Two of the block's functions can meet in the same cycle: the busy countdown and the decoding of a new command. The bench provokes this by issuing the array-read command in the cycle right after a program is accepted, while `busy` is high. It then judges the outcome through identifier-mode reads of a factory word: the read must still return the factory word, proving the command was ignored. The length of the busy window is counted at the `busy` port. The refusal path meets the lock state when a user-half program is issued after the lock bit has been cleared; there the bench expects both the error bit and unchanged data.

// File: rtl/otp_pkg.sv
package otp_pkg;
    typedef enum logic [1:0] {
        TGT_NONE = 2'd0,
        TGT_LOCK = 2'd1,
        TGT_FACT = 2'd2,
        TGT_USER = 2'd3
    } otp_tgt_e;

    localparam int          WORD_W      = 16;
    localparam logic [15:0] CMD_ID_READ = 16'h0090;
    localparam logic [15:0] CMD_ARRAY   = 16'h00FF;
    localparam logic [15:0] CMD_PSETUP  = 16'h00C0;
    localparam logic [15:0] LOCK_INIT   = 16'hFFFE;
endpackage

// File: rtl/otp_addr_map.sv
module otp_addr_map
    import otp_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int BASE      = 'h80,
    parameter int SEG_WORDS = 4,
    localparam int IDX_W    = (SEG_WORDS > 1) ? $clog2(SEG_WORDS) : 1
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              byte_mode,
    output otp_tgt_e          tgt,
    output logic [IDX_W-1:0]  idx,
    output logic              hi
);
    localparam logic [ADDR_W:0] BASE_W = (ADDR_W+1)'(BASE);
    localparam logic [ADDR_W:0] BASE_B = (ADDR_W+1)'(2 * BASE);
    localparam logic [ADDR_W:0] NSEG   = (ADDR_W+1)'(SEG_WORDS);

    logic [ADDR_W:0] ext;
    logic [ADDR_W:0] boff;
    logic [ADDR_W:0] woff;
    logic            hit;

    assign ext = {1'b0, addr};

    always_comb begin
        hit  = 1'b0;
        woff = '0;
        hi   = 1'b0;
        boff = '0;
        if (!byte_mode) begin
            if (ext >= BASE_W) begin
                hit  = 1'b1;
                woff = ext - BASE_W;
            end
        end else if (ext >= BASE_B) begin
            hit  = 1'b1;
            boff = ext - BASE_B;
            woff = boff >> 1;
            hi   = boff[0];
        end

        tgt = TGT_NONE;
        idx = '0;
        if (hit) begin
            if (woff == '0) begin
                tgt = TGT_LOCK;
            end else if (woff <= NSEG) begin
                tgt = TGT_FACT;
                idx = IDX_W'(woff - 1'b1);
            end else if (woff <= 2 * NSEG) begin
                tgt = TGT_USER;
                idx = IDX_W'(woff - NSEG - 1'b1);
            end
        end
    end
endmodule

// File: rtl/otp_store.sv
module otp_store
    import otp_pkg::*;
#(
    parameter int                SEG_BITS   = 64,
    parameter logic [SEG_BITS-1:0] FACTORY_ID = 64'h0123_4567_89AB_CDEF,
    localparam int SEG_WORDS = SEG_BITS / WORD_W,
    localparam int IDX_W     = (SEG_WORDS > 1) ? $clog2(SEG_WORDS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  otp_tgt_e          tgt,
    input  logic [IDX_W-1:0]  idx,
    input  logic              hi,
    input  logic              byte_mode,
    input  logic [15:0]       wdata,
    output logic [15:0]       rd_word,
    output logic              user_locked
);
    typedef struct packed {
        logic [15:0]         lock;
        logic [SEG_BITS-1:0] user;
    } store_t;

    store_t      s_d, s_q;
    logic [15:0] mask;
    logic [15:0] fact_w [SEG_WORDS];
    logic [15:0] user_w [SEG_WORDS];

    for (genvar g = 0; g < SEG_WORDS; g++) begin : g_words
        assign fact_w[g] = FACTORY_ID[g*WORD_W +: WORD_W];
        assign user_w[g] = s_q.user[g*WORD_W +: WORD_W];
    end

    always_comb begin
        if (!byte_mode) mask = wdata;
        else if (hi)    mask = {wdata[7:0], 8'hFF};
        else            mask = {8'hFF, wdata[7:0]};
    end

    always_comb begin
        s_d = s_q;
        if (we) begin
            case (tgt)
                TGT_LOCK: s_d.lock = s_q.lock & mask;
                TGT_USER: s_d.user[int'(idx)*WORD_W +: WORD_W] = user_w[idx] & mask;
                default:  s_d = s_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.lock <= LOCK_INIT;
            s_q.user <= '1;
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        case (tgt)
            TGT_LOCK: rd_word = s_q.lock;
            TGT_FACT: rd_word = fact_w[idx];
            TGT_USER: rd_word = user_w[idx];
            default:  rd_word = '0;
        endcase
    end

    assign user_locked = ~s_q.lock[1];
endmodule

// File: rtl/otp_ctrl.sv
module otp_ctrl
    import otp_pkg::*;
#(
    parameter int PROG_CYCLES = 8,
    localparam int CW = $clog2(PROG_CYCLES + 1)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic        byte_mode,
    input  logic [15:0] wdata,
    input  otp_tgt_e    tgt,
    input  logic        user_locked,
    output logic        id_mode,
    output logic        busy,
    output logic        prog_err,
    output logic        store_we
);
    typedef struct packed {
        logic          id_mode;
        logic          pend;
        logic          err;
        logic [CW-1:0] cnt;
    } ctrl_t;

    ctrl_t s_d, s_q;

    function automatic logic is_cmd(input logic [15:0] d, input logic bm,
                                    input logic [15:0] code);
        return bm ? (d[7:0] == code[7:0]) : (d == code);
    endfunction

    always_comb begin
        s_d      = s_q;
        store_we = 1'b0;
        if (s_q.cnt != '0) begin
            s_d.cnt = s_q.cnt - 1'b1;
        end else if (wr_en) begin
            if (s_q.pend) begin
                s_d.pend = 1'b0;
                if (tgt == TGT_LOCK || (tgt == TGT_USER && !user_locked)) begin
                    store_we = 1'b1;
                    s_d.err  = 1'b0;
                    s_d.cnt  = CW'(PROG_CYCLES);
                end else begin
                    s_d.err = 1'b1;
                end
            end else if (is_cmd(wdata, byte_mode, CMD_ID_READ)) begin
                s_d.id_mode = 1'b1;
            end else if (is_cmd(wdata, byte_mode, CMD_ARRAY)) begin
                s_d.id_mode = 1'b0;
            end else if (is_cmd(wdata, byte_mode, CMD_PSETUP)) begin
                s_d.pend = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign id_mode  = s_q.id_mode;
    assign busy     = (s_q.cnt != '0);
    assign prog_err = s_q.err;
endmodule

// File: rtl/otp_prot_ctrl.sv
module otp_prot_ctrl
    import otp_pkg::*;
#(
    parameter int                  ADDR_W      = 16,
    parameter int                  BASE        = 'h80,
    parameter int                  SEG_BITS    = 64,
    parameter logic [SEG_BITS-1:0] FACTORY_ID  = 64'h0123_4567_89AB_CDEF,
    parameter int                  PROG_CYCLES = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [15:0]       wdata,
    input  logic              byte_mode,
    output logic [15:0]       rdata,
    output logic              busy,
    output logic [7:0]        status
);
    localparam int SEG_WORDS = SEG_BITS / WORD_W;
    localparam int IDX_W     = (SEG_WORDS > 1) ? $clog2(SEG_WORDS) : 1;

    otp_tgt_e         tgt;
    logic [IDX_W-1:0] idx;
    logic             hi;
    logic [15:0]      rd_word;
    logic [15:0]      vis_word;
    logic             user_locked;
    logic             id_mode;
    logic             prog_err;
    logic             store_we;

    otp_addr_map #(.ADDR_W(ADDR_W), .BASE(BASE), .SEG_WORDS(SEG_WORDS)) i_map (
        .addr(addr), .byte_mode(byte_mode), .tgt(tgt), .idx(idx), .hi(hi)
    );

    otp_store #(.SEG_BITS(SEG_BITS), .FACTORY_ID(FACTORY_ID)) i_store (
        .clk(clk), .rst_n(rst_n), .we(store_we), .tgt(tgt), .idx(idx), .hi(hi),
        .byte_mode(byte_mode), .wdata(wdata), .rd_word(rd_word),
        .user_locked(user_locked)
    );

    otp_ctrl #(.PROG_CYCLES(PROG_CYCLES)) i_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .byte_mode(byte_mode),
        .wdata(wdata), .tgt(tgt), .user_locked(user_locked), .id_mode(id_mode),
        .busy(busy), .prog_err(prog_err), .store_we(store_we)
    );

    always_comb begin
        if (!id_mode)             vis_word = 16'hFFFF;
        else if (tgt == TGT_NONE) vis_word = 16'h0000;
        else                      vis_word = rd_word;

        if (!byte_mode) rdata = vis_word;
        else if (hi)    rdata = {8'h00, vis_word[15:8]};
        else            rdata = {8'h00, vis_word[7:0]};
    end

    assign status = {~busy, 2'b00, prog_err, 2'b00, user_locked, 1'b0};
endmodule

// File: rtl/otp_prot_ctrl_chk.sv
module otp_prot_ctrl_chk #(
    parameter int          ADDR_W      = 16,
    parameter int          BASE        = 'h80,
    parameter logic [15:0] FACT_LOW    = 16'hCDEF,
    parameter int          PROG_CYCLES = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic              byte_mode,
    input logic [15:0]       rdata,
    input logic              busy,
    input logic [7:0]        status
);
    logic [15:0] bcnt;

    always_ff @(posedge clk) begin
        if (!rst_n || !busy) bcnt <= '0;
        else                 bcnt <= bcnt + 1'b1;
    end

    // R8
    busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> bcnt == 16'(PROG_CYCLES));

    // R8
    busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(wr_en));

    // R8
    err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(status[4]));

    // R7
    lock_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        status[1] |=> status[1]);

    // R6
    factory_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!byte_mode && addr == ADDR_W'(BASE + 1)) |-> (rdata == 16'hFFFF || rdata == FACT_LOW));
endmodule

bind otp_prot_ctrl otp_prot_ctrl_chk #(
    .ADDR_W(ADDR_W), .BASE(BASE), .FACT_LOW(FACTORY_ID[15:0]), .PROG_CYCLES(PROG_CYCLES)
) i_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .byte_mode(byte_mode),
    .rdata(rdata), .busy(busy), .status(status)
);

// File: tb/test_otp_prot_ctrl.sv
`timescale 1ns/1ps
module test_otp_prot_ctrl;
    localparam logic [1:0] OW = 2'd0;  // write
    localparam logic [1:0] OR = 2'd1;  // read and compare rdata
    localparam logic [1:0] OS = 2'd2;  // wait idle, compare status
    localparam int NV = 47;
    // fields: op[54:53] bm[52] req[51:48] addr[47:32] data[31:16] exp[15:0]
    localparam logic [54:0] VEC [NV] = '{
        {OR, 1'b0, 4'd2, 16'h0081, 16'h0000, 16'hFFFF}, // R2 array mode
        {OS, 1'b0, 4'd1, 16'h0000, 16'h0000, 16'h0080}, // R1
        {OW, 1'b0, 4'd2, 16'h0000, 16'h0090, 16'h0000}, // R2 enter id
        {OR, 1'b0, 4'd3, 16'h0081, 16'h0000, 16'hCDEF}, // R3
        {OR, 1'b0, 4'd3, 16'h0084, 16'h0000, 16'h0123}, // R3
        {OR, 1'b0, 4'd3, 16'h0085, 16'h0000, 16'hFFFF}, // R3
        {OR, 1'b0, 4'd7, 16'h0080, 16'h0000, 16'hFFFE}, // R7 lock init
        {OR, 1'b0, 4'd2, 16'h0089, 16'h0000, 16'h0000}, // R2 unmapped
        {OW, 1'b0, 4'd5, 16'h0000, 16'h00C0, 16'h0000}, // R5 setup
        {OW, 1'b0, 4'd5, 16'h0085, 16'h1234, 16'h0000},
        {OS, 1'b0, 4'd8, 16'h0000, 16'h0000, 16'h0080}, // R8
        {OR, 1'b0, 4'd5, 16'h0085, 16'h0000, 16'h1234}, // R5
        {OR, 1'b0, 4'd9, 16'h0081, 16'h0000, 16'hCDEF}, // R9 still id
        {OW, 1'b0, 4'd5, 16'h0000, 16'h00C0, 16'h0000},
        {OW, 1'b0, 4'd5, 16'h0085, 16'hFF0F, 16'h0000},
        {OS, 1'b0, 4'd5, 16'h0000, 16'h0000, 16'h0080},
        {OR, 1'b0, 4'd5, 16'h0085, 16'h0000, 16'h1204}, // R5 AND
        {OW, 1'b0, 4'd6, 16'h0000, 16'h00C0, 16'h0000},
        {OW, 1'b0, 4'd6, 16'h0082, 16'h0000, 16'h0000},
        {OS, 1'b0, 4'd6, 16'h0000, 16'h0000, 16'h0090}, // R6 factory refused
        {OR, 1'b0, 4'd6, 16'h0082, 16'h0000, 16'h89AB}, // R6
        {OW, 1'b0, 4'd6, 16'h0000, 16'h00C0, 16'h0000},
        {OW, 1'b0, 4'd6, 16'h0090, 16'h0000, 16'h0000},
        {OS, 1'b0, 4'd6, 16'h0000, 16'h0000, 16'h0090}, // R6 out of range
        {OW, 1'b0, 4'd6, 16'h0000, 16'h00C0, 16'h0000},
        {OW, 1'b0, 4'd6, 16'h0086, 16'hAAAA, 16'h0000},
        {OS, 1'b0, 4'd6, 16'h0000, 16'h0000, 16'h0080}, // R6 cleared
        {OR, 1'b0, 4'd6, 16'h0086, 16'h0000, 16'hAAAA},
        {OW, 1'b1, 4'd4, 16'h0000, 16'h12C0, 16'h0000}, // R4 low byte cmd
        {OW, 1'b1, 4'd4, 16'h010F, 16'h005A, 16'h0000},
        {OS, 1'b1, 4'd4, 16'h0000, 16'h0000, 16'h0080},
        {OR, 1'b1, 4'd4, 16'h010F, 16'h0000, 16'h005A}, // R4
        {OR, 1'b0, 4'd4, 16'h0087, 16'h0000, 16'h5AFF}, // R4 lane
        {OR, 1'b1, 4'd4, 16'h0102, 16'h0000, 16'h00EF},
        {OR, 1'b1, 4'd4, 16'h0103, 16'h0000, 16'h00CD},
        {OR, 1'b1, 4'd4, 16'h0111, 16'h0000, 16'h00FF},
        {OW, 1'b0, 4'd7, 16'h0000, 16'h00C0, 16'h0000},
        {OW, 1'b0, 4'd7, 16'h0080, 16'hFFFD, 16'h0000},
        {OS, 1'b0, 4'd7, 16'h0000, 16'h0000, 16'h0082}, // R7 locked
        {OR, 1'b0, 4'd7, 16'h0080, 16'h0000, 16'hFFFC},
        {OW, 1'b0, 4'd7, 16'h0000, 16'h00C0, 16'h0000},
        {OW, 1'b0, 4'd7, 16'h0088, 16'h0000, 16'h0000},
        {OS, 1'b0, 4'd7, 16'h0000, 16'h0000, 16'h0092}, // R7 refused
        {OR, 1'b0, 4'd7, 16'h0088, 16'h0000, 16'hFFFF},
        {OW, 1'b0, 4'd2, 16'h0000, 16'h00FF, 16'h0000}, // R2 array cmd
        {OR, 1'b0, 4'd2, 16'h0085, 16'h0000, 16'hFFFF},
        {OR, 1'b1, 4'd2, 16'h0102, 16'h0000, 16'h00FF}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] addr = '0;
    logic [15:0] wdata = '0;
    logic        byte_mode = 1'b0;
    logic [15:0] rdata;
    logic        busy;
    logic [7:0]  status;
    int          n_chk = 0;
    int          n_bad = 0;
    bit          done = 1'b0;

    always #4 clk = ~clk;

    otp_prot_ctrl i_otp_prot_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .byte_mode(byte_mode), .rdata(rdata), .busy(busy), .status(status)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic bm, input logic [15:0] a, input logic [15:0] d);
        @(negedge clk);
        byte_mode = bm; addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_read(input string req, input logic bm, input logic [15:0] a,
                           input logic [15:0] exp);
        @(negedge clk);
        byte_mode = bm; addr = a;
        #1;
        check(req, rdata, exp);
    endtask

    task automatic wait_idle();
        for (int k = 0; k < 100 && busy; k++) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        int bcycles;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < NV; i++) begin
            logic [54:0] v;
            string rq;
            v  = VEC[i];
            rq = $sformatf("R%0d vec%0d", v[51:48], i);
            case (v[54:53])
                OW: do_write(v[52], v[47:32], v[31:16]);
                OR: do_read(rq, v[52], v[47:32], v[15:0]);
                default: begin
                    wait_idle();
                    @(negedge clk);
                    #1;
                    check(rq, {8'h00, status}, v[15:0]);
                end
            endcase
        end

        // R1 reset returns blank image and array mode
        do_reset();
        #1;
        check("R1 status", {8'h00, status}, 16'h0080);
        do_read("R1 array", 1'b0, 16'h0085, 16'hFFFF);
        do_write(1'b0, 16'h0000, 16'h0090);
        do_read("R1 user blank", 1'b0, 16'h0085, 16'hFFFF);
        do_read("R1 lock init", 1'b0, 16'h0080, 16'hFFFE);

        // R8 busy length
        do_write(1'b0, 16'h0000, 16'h00C0);
        do_write(1'b0, 16'h0085, 16'h00FF);
        bcycles = 0;
        for (int k = 0; k < 50 && busy; k++) begin
            bcycles++;
            @(negedge clk);
        end
        check("R8 busy cycles", 16'(bcycles), 16'd8);

        // R8 command during busy is ignored
        do_write(1'b0, 16'h0000, 16'h00C0);
        do_write(1'b0, 16'h0086, 16'h0F0F);
        #1;
        check("R8 busy high", {15'd0, busy}, 16'd1);
        check("R8 ready low", {15'd0, status[7]}, 16'd0);
        do_write(1'b0, 16'h0000, 16'h00FF);
        wait_idle();
        do_read("R8 ignored cmd", 1'b0, 16'h0081, 16'hCDEF);
        do_read("R5 prog", 1'b0, 16'h0086, 16'h0F0F);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(8 * 100000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule